// File: doc/BRIEF.md
# Single-Wire Bus Slave Command Engine

This block is the device end of a single-wire, pulse-width-coded control bus. A separate classifier measures each low pulse on the line and hands this block one symbol per pulse: a zero (which doubles as a read prompt), a one, a transaction marker, an initialization-time pulse, or an error. The block decodes a command from those symbols and keeps two pieces of state. The first is a 4-bit device identity, given to the device during an initialization sequence. The second is an 8-bit control word, which drives the video-path control outputs.

A command opens with a marker and a 3-bit opcode, and it closes with a marker followed by the bits 111. The five commands are:
- address select, which marks one device on the shared bus as the target;
- write, which loads the selected device;
- read, which returns the control word bit by bit after each prompt;
- broadcast, which loads every device;
- initialization, which assigns the identity.

A payload takes effect only when its closing marker arrives. Writing all ones acts as a software reset. For readback the block pulls the line low through an open-drain enable, and it holds that pull for a fixed window after each prompt's falling edge.

Top module: `swb_slave_ctrl`

## Requirements
- R1: After reset the control word is 0110_0000: `in_sel`=1 and `filt_en`=1, every other field output is 0, `line_pull`=0 and no identity is assigned.
- R2: A marker followed by three bits forms an opcode, written with the first-sent bit leftmost. 010 is address, 001 is write, 101 is read, 000 is broadcast and 011 is initialize. A marker followed by 111 ends the command, and any payload takes effect only at that point.
- R3: An address payload is the last 4 bits sent, LSB first. The device becomes selected only when it has an assigned identity equal to that payload. Any other complete address deselects it.
- R4: A write takes effect only when the device is selected at the opcode. At least 8 data bits must be sent, LSB first, and only the last 8 are kept. A write with fewer than 8 bits leaves the control word unchanged.
- R5: A broadcast loads the control word whether or not the device is selected and whether or not it has an identity.
- R6: During a read, each falling edge on `line_fall` presents the next control-word bit, starting at bit 0. A bit of 1 asserts `line_pull` for HOLD_CYC cycles; a bit of 0 leaves the line released. After bit 7 the sequence wraps to bit 0.
- R7: A read issued while the device is not selected never asserts `line_pull`.
- R8: Loading all ones, by broadcast or by addressed write, restores the R1 state. This also clears the assigned identity and the selected flag.
- R9: An initialization sequence assigns the last 4 ID bits sent, LSB first. The sequence is the marker with 011, then an init-time pulse, then the ID bits, then the marker with 111. It is honoured only while `init_eligible`=1 and no identity is assigned; otherwise it is ignored.
- R10: An error symbol aborts the command in progress, and its pending payload is discarded.
- R11: Control word bit 7 is `sync_dir`, bit 6 `in_sel`, bit 5 `filt_en`, bit 4 `clamp_hi`, bits 3:2 `boost[1:0]` and bit 1 `out_dis`. Bit 0 is a spare that is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | One-cycle strobe: a classified symbol is present |
| sym_kind | input | 3 | Symbol code: 0 zero/prompt, 1 one, 2 marker, 3 init-time, 4 error |
| line_fall | input | 1 | One-cycle strobe at each falling edge of the bus line |
| init_eligible | input | 1 | High while this device may accept an identity |
| line_pull | output | 1 | Open-drain enable that pulls the bus line low |
| sync_dir | output | 1 | Sync pin direction (1 = input) |
| in_sel | output | 1 | Input select (1 = input A) |
| filt_en | output | 1 | 1 = filter in path, 0 = bypass |
| clamp_hi | output | 1 | Clamp level select (1 = high level) |
| boost | output | 2 | High-frequency boost step |
| out_dis | output | 1 | Output disable (1 = high impedance) |

## Verification
The assertions take three things for granted about the inputs. First, `line_fall` and `sym_valid` are single-cycle strobes. Second, the classifier reports one symbol per pulse. Third, the closing marker of a read arrives only after the last hold window has expired. The stimulus keeps within these limits: every symbol is a lone strobe followed by idle cycles, and after each prompt edge the bench waits longer than HOLD_CYC before sending the prompt's own symbol. The sweep broadcasts every control value except all ones, and it checks each field output arithmetically from the value sent.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [2:0] {
    SYM_ZERO = 3'd0,
    SYM_ONE  = 3'd1,
    SYM_MARK = 3'd2,
    SYM_INIT = 3'd3,
    SYM_ERR  = 3'd4
  } sym_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_INIT_T,
    PH_INIT_ID,
    PH_SKIP
  } phase_e;

  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OP_ADDR = 3'b010;
  localparam logic [OPC_W-1:0] OP_WR   = 3'b001;
  localparam logic [OPC_W-1:0] OP_RD   = 3'b101;
  localparam logic [OPC_W-1:0] OP_BC   = 3'b000;
  localparam logic [OPC_W-1:0] OP_INIT = 3'b011;
  localparam logic [OPC_W-1:0] OP_END  = 3'b111;
endpackage

// File: rtl/swb_cmd_seq.sv
module swb_cmd_seq
  import swb_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [2:0]       sym_kind,
  input  logic             sel,
  input  logic             idv,
  input  logic             init_ok,
  output logic             addr_ev,
  output logic             data_ev,
  output logic             id_ev,
  output logic             rd_start,
  output logic             rd_active,
  output logic [REG_W-1:0] shv
);
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] ID_N  = CNT_W'(ID_W);
  localparam logic [CNT_W-1:0] REG_N = CNT_W'(REG_W);

  phase_e           ph, body, start_ph;
  sym_e             kind;
  logic [OPC_W-1:0] op, nop;
  logic [1:0]       ocnt;
  logic [CNT_W-1:0] dcnt;
  logic [REG_W-1:0] sh;
  logic             bitv;

  assign kind      = sym_e'(sym_kind);
  assign bitv      = (kind == SYM_ONE);
  assign nop       = {op[OPC_W-2:0], bitv};
  assign rd_active = (ph == PH_READ);
  assign shv       = sh;

  // Opcode decode: the phase the command body runs in.
  always_comb begin
    case (nop)
      OP_ADDR: start_ph = PH_ADDR;
      OP_WR:   start_ph = sel ? PH_DATA : PH_SKIP;
      OP_BC:   start_ph = PH_DATA;
      OP_RD:   start_ph = sel ? PH_READ : PH_SKIP;
      OP_INIT: start_ph = (init_ok && !idv) ? PH_INIT_T : PH_SKIP;
      default: start_ph = PH_SKIP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      body     <= PH_IDLE;
      op       <= '0;
      ocnt     <= '0;
      dcnt     <= '0;
      sh       <= '0;
      addr_ev  <= 1'b0;
      data_ev  <= 1'b0;
      id_ev    <= 1'b0;
      rd_start <= 1'b0;
    end else begin
      addr_ev  <= 1'b0;
      data_ev  <= 1'b0;
      id_ev    <= 1'b0;
      rd_start <= 1'b0;
      if (sym_valid) begin
        case (kind)
          SYM_ERR: ph <= PH_IDLE;
          SYM_MARK: begin
            body <= (ph == PH_OPC) ? PH_IDLE : ph;
            ph   <= PH_OPC;
            op   <= '0;
            ocnt <= '0;
          end
          SYM_INIT: begin
            if (ph == PH_INIT_T) begin
              ph   <= PH_INIT_ID;
              dcnt <= '0;
            end
          end
          SYM_ZERO, SYM_ONE: begin
            if (ph == PH_OPC) begin
              op   <= nop;
              ocnt <= ocnt + 2'd1;
              if (ocnt == 2'd2) begin
                dcnt <= '0;
                if (nop == OP_END) begin
                  ph <= PH_IDLE;
                  case (body)
                    PH_ADDR:    addr_ev <= (dcnt >= ID_N);
                    PH_DATA:    data_ev <= (dcnt >= REG_N);
                    PH_INIT_ID: id_ev   <= (dcnt >= ID_N);
                    default: ;
                  endcase
                end else begin
                  ph <= start_ph;
                end
                if (nop == OP_RD && sel) rd_start <= 1'b1;
              end
            end else if (ph == PH_ADDR || ph == PH_DATA || ph == PH_INIT_ID) begin
              sh <= {bitv, sh[REG_W-1:1]};
              if (dcnt != REG_N) dcnt <= dcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swb_ctrl_bank.sv
module swb_ctrl_bank #(
  parameter int              ID_W    = 4,
  parameter int              REG_W   = 8,
  parameter logic [REG_W-1:0] REG_RST = 8'h60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_ev,
  input  logic             data_ev,
  input  logic             id_ev,
  input  logic [REG_W-1:0] shv,
  output logic [REG_W-1:0] ctrl,
  output logic             sel,
  output logic             idv
);
  logic [ID_W-1:0] my_id;
  logic [ID_W-1:0] last_id;
  logic            soft_rst;

  assign last_id  = shv[REG_W-1 -: ID_W];
  assign soft_rst = data_ev && (&shv);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl  <= REG_RST;
      sel   <= 1'b0;
      idv   <= 1'b0;
      my_id <= '0;
    end else begin
      if (data_ev) ctrl <= shv;
      if (addr_ev) sel <= idv && (last_id == my_id);
      if (id_ev) begin
        my_id <= last_id;
        idv   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swb_readback.sv
module swb_readback #(
  parameter int REG_W    = 8,
  parameter int HOLD_CYC = 960
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_start,
  input  logic             rd_active,
  input  logic             line_fall,
  input  logic [REG_W-1:0] ctrl,
  output logic             line_pull
);
  localparam int PTR_W = $clog2(REG_W);
  localparam int HW    = $clog2(HOLD_CYC + 1);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(REG_W - 1);
  localparam logic [HW-1:0]    HOLD_N = HW'(HOLD_CYC);

  logic [PTR_W-1:0] ptr;
  logic [HW-1:0]    hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      hcnt      <= '0;
      line_pull <= 1'b0;
    end else if (rd_start) begin
      ptr <= '0;
    end else if (rd_active && line_fall) begin
      line_pull <= ctrl[ptr];
      hcnt      <= HOLD_N;
      ptr       <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end else if (hcnt != '0) begin
      hcnt <= hcnt - 1'b1;
      if (hcnt == HW'(1)) line_pull <= 1'b0;
    end
  end
endmodule

// File: rtl/swb_slave_ctrl.sv
module swb_slave_ctrl #(
  parameter int               ID_W     = 4,
  parameter int               REG_W    = 8,
  parameter logic [REG_W-1:0] REG_RST  = 8'h60,
  parameter int               HOLD_CYC = 960
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  input  logic [2:0] sym_kind,
  input  logic       line_fall,
  input  logic       init_eligible,
  output logic       line_pull,
  output logic       sync_dir,
  output logic       in_sel,
  output logic       filt_en,
  output logic       clamp_hi,
  output logic [1:0] boost,
  output logic       out_dis
);
  localparam int TOP = REG_W - 1;

  logic             addr_ev_w, data_ev_w, id_ev_w, rd_start_w, rd_act_w;
  logic             sel_w, idv_w;
  logic [REG_W-1:0] shv_w, ctrl_w;

  swb_cmd_seq #(.ID_W(ID_W), .REG_W(REG_W)) seq_i (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .sel(sel_w), .idv(idv_w), .init_ok(init_eligible),
    .addr_ev(addr_ev_w), .data_ev(data_ev_w), .id_ev(id_ev_w),
    .rd_start(rd_start_w), .rd_active(rd_act_w), .shv(shv_w)
  );

  swb_ctrl_bank #(.ID_W(ID_W), .REG_W(REG_W), .REG_RST(REG_RST)) bank_i (
    .clk(clk), .rst(rst), .addr_ev(addr_ev_w), .data_ev(data_ev_w),
    .id_ev(id_ev_w), .shv(shv_w), .ctrl(ctrl_w), .sel(sel_w), .idv(idv_w)
  );

  swb_readback #(.REG_W(REG_W), .HOLD_CYC(HOLD_CYC)) rb_i (
    .clk(clk), .rst(rst), .rd_start(rd_start_w), .rd_active(rd_act_w),
    .line_fall(line_fall), .ctrl(ctrl_w), .line_pull(line_pull)
  );

  assign sync_dir = ctrl_w[TOP];
  assign in_sel   = ctrl_w[TOP-1];
  assign filt_en  = ctrl_w[TOP-2];
  assign clamp_hi = ctrl_w[TOP-3];
  assign boost    = ctrl_w[TOP-4 -: 2];
  assign out_dis  = ctrl_w[TOP-6];
endmodule

// File: rtl/swb_slave_chk.sv
module swb_slave_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [2:0]       sym_kind,
  input logic             line_fall,
  input logic             line_pull,
  input logic             sel,
  input logic             idv,
  input logic [REG_W-1:0] ctrl,
  input logic             data_ev,
  input logic             rd_active
);
  a_r6_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pull) |-> $past(line_fall));

  a_r7_pull_only_in_read: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pull) |-> $past(rd_active));

  a_r3_sel_needs_id: assert property (@(posedge clk) disable iff (rst)
    sel |-> idv);

  a_r4_ctrl_changes_on_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl) |-> $past(data_ev));

  a_r10_error_leaves_read: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == 3'd4) |=> !rd_active);
endmodule

bind swb_slave_ctrl swb_slave_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
  .line_fall(line_fall), .line_pull(line_pull), .sel(sel_w), .idv(idv_w),
  .ctrl(ctrl_w), .data_ev(data_ev_w), .rd_active(rd_act_w)
);

// File: tb/swb_slave_ctrl_tb.sv
`timescale 1ns/1ps
module swb_slave_ctrl_tb_top;
  localparam int HOLD = 20;
  localparam logic [2:0] K0 = 3'd0, K1 = 3'd1, KM = 3'd2, KI = 3'd3, KE = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [2:0] sym_kind = 3'd0;
  logic line_fall = 1'b0;
  logic init_eligible = 1'b0;
  logic line_pull, sync_dir, in_sel, filt_en, clamp_hi, out_dis;
  logic [1:0] boost;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_reg;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  swb_slave_ctrl #(.HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .line_fall(line_fall), .init_eligible(init_eligible), .line_pull(line_pull),
    .sync_dir(sync_dir), .in_sel(in_sel), .filt_en(filt_en), .clamp_hi(clamp_hi),
    .boost(boost), .out_dis(out_dis)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_sym(input logic [2:0] k);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_kind  = k;
    @(negedge clk);
    sym_valid = 1'b0;
    tick(3);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) send_sym(v[i] ? K1 : K0);
  endtask

  task automatic open_cmd(input logic [2:0] op);
    send_sym(KM);
    send_sym(op[2] ? K1 : K0);
    send_sym(op[1] ? K1 : K0);
    send_sym(op[0] ? K1 : K0);
  endtask

  task automatic close_cmd();
    open_cmd(3'b111);
  endtask

  task automatic do_addr(input logic [3:0] id);
    open_cmd(3'b010); send_bits({12'd0, id}, 4); close_cmd();
  endtask

  task automatic do_write(input logic [15:0] v, input int n);
    open_cmd(3'b001); send_bits(v, n); close_cmd();
  endtask

  task automatic do_bcast(input logic [15:0] v, input int n);
    open_cmd(3'b000); send_bits(v, n); close_cmd();
  endtask

  task automatic do_init(input logic [3:0] id);
    open_cmd(3'b011); send_sym(KI); send_bits({12'd0, id}, 4); close_cmd();
  endtask

  task automatic read_reg(input int n, output logic [15:0] got);
    got = '0;
    open_cmd(3'b101);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_fall = 1'b1;
      @(negedge clk); line_fall = 1'b0;
      tick(3);
      got[i] = line_pull;
      tick(HOLD + 2);
      send_sym(K0);
    end
    close_cmd();
  endtask

  task automatic chk_fields(input string tag, input logic [7:0] e);
    chk(tag, {24'd0, sync_dir, in_sel, filt_en, clamp_hi, boost, out_dis, 1'b0},
        {24'd0, e[7:1], 1'b0});
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    exp_reg = 8'h60;
    chk_fields("R1 reset fields", exp_reg);
    chk("R1 reset line_pull", {31'd0, line_pull}, 32'd0);

    read_reg(8, rd);
    chk("R7 read unassigned", {16'd0, rd}, 32'd0);

    init_eligible = 1'b0;
    do_init(4'd5); do_addr(4'd5); do_write(16'h3C, 8);
    chk_fields("R9 init ignored when ineligible", exp_reg);

    init_eligible = 1'b1;
    do_init(4'd5); do_addr(4'd5); do_write(16'h3C, 8);
    exp_reg = 8'h3C;
    chk_fields("R9 R3 R4 init address write", exp_reg);

    do_addr(4'd6); do_write(16'h11, 8);
    chk_fields("R3 other address deselects", exp_reg);

    do_addr(4'd5); do_write(16'hA53, 12);
    exp_reg = 8'hA5;
    chk_fields("R4 keeps last 8 bits", exp_reg);

    do_write(16'h1F, 5);
    chk_fields("R4 short write ignored", exp_reg);

    read_reg(10, rd);
    begin
      logic [15:0] e10;
      e10 = '0;
      for (int i = 0; i < 10; i++) e10[i] = exp_reg[i % 8];
      chk("R6 readback with wrap", {16'd0, rd}, {16'd0, e10});
    end

    for (int v = 0; v < 255; v++) begin
      do_bcast(16'(v), 8);
      exp_reg = 8'(v);
      chk_fields("R5 R11 broadcast field map", exp_reg);
      if (v % 16 == 3) begin
        read_reg(8, rd);
        chk("R6 R11 readback incl spare bit", {16'd0, rd}, {24'd0, exp_reg});
      end
    end

    open_cmd(3'b001); send_bits(16'h0F, 8); send_sym(KE); close_cmd();
    chk_fields("R10 error aborts write", exp_reg);

    open_cmd(3'b011); send_sym(KE); send_sym(KI); send_bits(16'h9, 4); close_cmd();
    do_init(4'd9); do_addr(4'd9);
    read_reg(8, rd);
    chk("R9 second init ignored", {16'd0, rd}, 32'd0);
    do_addr(4'd5);
    read_reg(8, rd);
    chk("R3 original id still selects", {16'd0, rd}, {24'd0, exp_reg});

    do_write(16'hFFF, 12);
    exp_reg = 8'h60;
    chk_fields("R8 addressed all-ones reset", exp_reg);
    do_addr(4'd5); do_write(16'h00, 8);
    chk_fields("R8 id cleared after reset", exp_reg);
    do_bcast(16'h00, 8);
    exp_reg = 8'h00;
    chk_fields("R5 broadcast without id", exp_reg);
    do_bcast(16'h1FF, 9);
    exp_reg = 8'h60;
    chk_fields("R8 broadcast all-ones reset", exp_reg);
    chk("R2 R8 line idle", {31'd0, line_pull}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule